// File: doc/BRIEF.md
# Timer-Paced SPI ADC Capture Engine

This block is an SPI master that reads an external serial converter at a fixed sample rate without any processor work per sample. An internal reload timer paces the conversions. Each time the timer reaches zero, the engine opens one conversion frame. In that frame it holds chip-select low for 22 serial clocks and shifts in the converter's reply, most significant bit first. It then keeps a chosen bit range of the 22 bits as the result and stores that result in a sample buffer.

The buffer has two halves that are used in turn. The engine fills one half while the host reads the other. When the number of samples set by configuration has been stored, that half is marked ready and the host is told which half it is. The host is signalled once per block, not once per sample.

The engine reports trouble through one sticky overflow flag. The flag is set when a frame is still in progress at the next timer expiry, or when both halves are still held by the host as a new sample arrives. In both cases the new sample is lost. Clearing the run input lets the current frame finish, and no further frame starts.

Top module: `spi_adc_capture`

## Requirements
- R1: A frame is one continuous chip-select-low period with exactly 22 rising serial-clock edges. The serial clock idles low and is high only while chip-select is low.
- R2: Each serial-clock half period lasts `cfg_div` system clocks (`cfg_div` >= 1). Chip-select falls `cfg_div` clocks before the first rising edge and rises `cfg_div` clocks after the last falling edge.
- R3: The input `spi_miso` is sampled on each rising serial-clock edge, first bit as the most significant, giving a 22-bit word. The stored result is the low DW bits of that word shifted right by `cfg_shift`.
- R4: While `run` is high, a frame starts every `cfg_period`+1 clocks. The first frame's chip-select falls `cfg_period`+1 clocks after `run` is first seen high.
- R5: Chip-select stays high for at least two serial-clock periods (4*`cfg_div` clocks) between frames.
- R6: Results are written in order into the current half, half 0 first. After `cfg_blk_last`+1 results that half becomes ready, and writing moves to the other half.
- R7: `blk_ready` is high while a half is ready, and `blk_half` names it (0 or 1). `host_rdata` returns entry `host_addr` of that half one clock after the address is applied. A `host_release` pulse frees the half and points to the other one. A release while nothing is ready has no effect.
- R8: A timer expiry while a frame or its chip-select-high gap is in progress starts no frame and sets `overflow`.
- R9: A result that completes while both halves are ready is dropped and sets `overflow`. Stored halves and the write position are unchanged.
- R10: `overflow` stays set until reset.
- R11: Lowering `run` during a frame lets that frame complete and be stored, and no further frame starts.
- R12: After reset `spi_cs_n`=1, `spi_sclk`=0, `blk_ready`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Level enable for timer-paced capture |
| cfg_period | input | TW | Sample interval minus one, in clocks |
| cfg_div | input | DIVW | Serial-clock half period in clocks |
| cfg_shift | input | $clog2(FRAME_BITS) | Right shift applied to the 22-bit word |
| cfg_blk_last | input | AW | Samples per block minus one |
| spi_cs_n | output | 1 | Converter chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_miso | input | 1 | Serial data from the converter |
| host_addr | input | AW | Read index inside the ready half |
| host_release | input | 1 | Frees the ready half |
| host_rdata | output | DW | Read data, one clock latency |
| blk_ready | output | 1 | A filled half waits for the host |
| blk_half | output | 1 | Index of the half offered to the host |
| overflow | output | 1 | Sticky lost-sample flag |

## Verification
The converter model returns a different computed 22-bit word in every frame. The bench sweeps three clock dividers against three extraction shifts, which separates errors in bit order and in the shifted range from errors in serial timing. Two-block runs with a half still held show whether the halves alternate and whether reads come from the offered half. Separate runs check the two overflow causes: a short timer period shows dropped starts as tripled frame spacing, and an unreleased buffer shows one missing sample value. A stop issued in the middle of a frame shows that the frame still completes.

// File: rtl/spi_adc_capture.sv
module spi_adc_capture #(
  parameter int DW = 16,
  parameter int FRAME_BITS = 22,
  parameter int TW = 16,
  parameter int AW = 10,
  parameter int DIVW = 8,
  localparam int SHW = $clog2(FRAME_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TW-1:0]   cfg_period,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [SHW-1:0]  cfg_shift,
  input  logic [AW-1:0]   cfg_blk_last,
  output logic            spi_cs_n,
  output logic            spi_sclk,
  input  logic            spi_miso,
  input  logic [AW-1:0]   host_addr,
  input  logic            host_release,
  output logic [DW-1:0]   host_rdata,
  output logic            blk_ready,
  output logic            blk_half,
  output logic            overflow
);
  localparam int DEPTH     = 1 << AW;
  localparam int PH_LAST_HI = 2 * FRAME_BITS - 1;
  localparam int PH_CS_END = 2 * FRAME_BITS;
  localparam int PH_DONE   = 2 * FRAME_BITS + 4;
  localparam int PHW       = $clog2(PH_DONE + 2);

  logic [TW-1:0]         tmr;
  logic                  busy;
  logic [PHW-1:0]        ph;
  logic [DIVW-1:0]       hc;
  logic [FRAME_BITS-1:0] sr;
  logic                  sclk_q, cs_n_q, ovf_q;
  logic [AW-1:0]         wr_idx;
  logic                  wr_half, rd_half;
  logic [1:0]            full;
  logic [DW-1:0]         mem [2*DEPTH];

  wire tick = (tmr == '0);
  wire start = run && tick && !busy;
  wire [DIVW-1:0] hc_load = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
  wire ph_step = busy && (hc == '0);
  wire [PHW-1:0] ph_nx = ph + 1'b1;
  wire nx_hi = ph_nx[0] && (ph_nx <= PHW'(PH_LAST_HI));
  wire sample_done = ph_step && (ph == PHW'(PH_CS_END));
  wire frame_end = ph_step && (ph == PHW'(PH_DONE));
  wire [DW-1:0] result = DW'(sr >> cfg_shift);
  wire wr_ok = !full[wr_half];
  wire blk_end = (wr_idx >= cfg_blk_last);
  wire fill = sample_done && wr_ok && blk_end;
  wire rel = host_release && full[rd_half];
  wire [1:0] fill_m = {fill && wr_half, fill && !wr_half};
  wire [1:0] rel_m = {rel && rd_half, rel && !rd_half};

  always_ff @(posedge clk) begin
    if (!rst_n)             tmr <= '0;
    else if (!run || tick)  tmr <= cfg_period;
    else                    tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= '0; hc <= '0; sr <= '0;
      sclk_q <= 1'b0; cs_n_q <= 1'b1;
    end else if (start) begin
      busy <= 1'b1; ph <= '0; hc <= hc_load;
      sclk_q <= 1'b0; cs_n_q <= 1'b0;
    end else if (ph_step) begin
      hc <= hc_load;
      if (frame_end) busy <= 1'b0;
      else           ph <= ph_nx;
      sclk_q <= nx_hi;
      cs_n_q <= (ph_nx > PHW'(PH_CS_END));
      if (nx_hi) sr <= {sr[FRAME_BITS-2:0], spi_miso};
    end else if (busy) begin
      hc <= hc - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if ((run && tick && busy) || (sample_done && !wr_ok)) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (sample_done && wr_ok) mem[{wr_half, wr_idx}] <= result;
    host_rdata <= mem[{rd_half, host_addr}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0; wr_half <= 1'b0; rd_half <= 1'b0; full <= 2'b00;
    end else begin
      if (sample_done && wr_ok) begin
        if (blk_end) begin
          wr_idx <= '0;
          wr_half <= ~wr_half;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
      full <= (full | fill_m) & ~rel_m;
      if (rel) rd_half <= ~rd_half;
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign blk_ready = full[rd_half];
  assign blk_half  = rd_half;
  assign overflow  = ovf_q;

  localparam int EW = $clog2(FRAME_BITS + 1) + 1;
  logic [EW-1:0] a_edges;
  logic [15:0]   a_hi_cnt;
  logic          a_sclk_d, a_cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_edges <= '0; a_hi_cnt <= '1; a_sclk_d <= 1'b0; a_cs_d <= 1'b1;
    end else begin
      a_sclk_d <= sclk_q;
      a_cs_d <= cs_n_q;
      if (cs_n_q) a_hi_cnt <= (a_hi_cnt == '1) ? a_hi_cnt : a_hi_cnt + 1'b1;
      else        a_hi_cnt <= '0;
      if (a_cs_d && !cs_n_q)        a_edges <= '0;
      else if (sclk_q && !a_sclk_d) a_edges <= a_edges + 1'b1;
    end
  end

  p_sclk_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);
  p_edge_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (a_edges == EW'(FRAME_BITS)));
  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (32'(a_hi_cnt) >= 4 * (32'(hc_load) + 1)));
  p_release_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_release && blk_ready) |=> (blk_half != $past(blk_half)));
  p_drop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && full == 2'b11) |=> ($stable(wr_idx) && $stable(wr_half)));
  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: tb/spi_adc_capture_tb_top.sv
module spi_adc_capture_tb_top;
  localparam int DW = 12, FB = 22, TW = 10, AW = 3, DIVW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run, spi_miso, host_release;
  logic [TW-1:0] cfg_period;
  logic [DIVW-1:0] cfg_div;
  logic [4:0] cfg_shift;
  logic [AW-1:0] cfg_blk_last, host_addr;
  logic spi_cs_n, spi_sclk, blk_ready, blk_half, overflow;
  logic [DW-1:0] host_rdata;

  spi_adc_capture #(.DW(DW), .FRAME_BITS(FB), .TW(TW), .AW(AW), .DIVW(DIVW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_period(cfg_period), .cfg_div(cfg_div),
    .cfg_shift(cfg_shift), .cfg_blk_last(cfg_blk_last), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_miso(spi_miso), .host_addr(host_addr),
    .host_release(host_release), .host_rdata(host_rdata), .blk_ready(blk_ready),
    .blk_half(blk_half), .overflow(overflow));

  int total = 0, bad = 0, cyc = 0, fcnt = 0, frames_done = 0;
  int iv_first, iv_later, iv_exp, last_fall;
  bit have_last = 0;
  logic [FB-1:0] seed = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [FB-1:0] fval(int i);
    logic [31:0] m = i * 32'h0002_A5B7;
    return m[FB-1:0] ^ seed ^ ((i % 2 == 1) ? 22'h15_5555 : 22'h0);
  endfunction

  function automatic logic [DW-1:0] exp_res(int i, int sh);
    logic [FB-1:0] v = fval(i) >> sh;
    return v[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; run = 1'b0; host_release = 1'b0; host_addr = '0;
    repeat (3) step;
    rst_n = 1'b1; fcnt = 0; frames_done = 0; have_last = 0;
    step;
  endtask

  task automatic start_run(input int first, input int later);
    iv_first = first; iv_later = later; iv_exp = first;
    last_fall = cyc; have_last = 1; run = 1'b1;
  endtask

  task automatic stop_run;
    run = 1'b0; have_last = 0;
  endtask

  task automatic wait_frames(input int n);
    while (frames_done < n) step;
  endtask

  task automatic read_check(input int base, input int n, input int sh, input string req);
    for (int j = 0; j < n; j++) begin
      host_addr = AW'(j);
      step;
      chk(host_rdata == exp_res(base + j, sh), req, int'(host_rdata), int'(exp_res(base + j, sh)));
    end
  endtask

  task automatic release_pulse;
    host_release = 1'b1; step; host_release = 1'b0;
  endtask

  // converter model: new bit after each falling serial-clock edge
  initial begin
    logic [FB-1:0] cur;
    spi_miso = 1'b0;
    forever begin
      @(negedge spi_cs_n);
      cur = fval(fcnt);
      fcnt++;
      spi_miso = cur[FB-1];
      for (int k = 1; k < FB; k++) begin
        @(negedge spi_sclk);
        spi_miso = cur[FB-1-k];
      end
    end
  end

  // frame shape monitor: R1 R2 R4 R5
  initial begin
    bit p_cs, p_sclk, in_frame;
    int lvl, edges, gap, d;
    p_cs = 1; p_sclk = 0; in_frame = 0; lvl = 0; edges = 0; gap = 1000;
    forever begin
      @(negedge clk);
      if (rst_n !== 1'b1) begin
        p_cs = 1; p_sclk = 0; in_frame = 0; gap = 1000;
        continue;
      end
      d = int'(cfg_div);
      if (spi_sclk && spi_cs_n) chk(0, "R1 sclk high outside frame", 1, 0);
      if (p_cs && !spi_cs_n) begin
        chk(gap >= 4 * d, "R5 chip-select high gap", gap, 4 * d);
        if (have_last) begin
          chk(cyc - last_fall == iv_exp, "R4 frame start interval", cyc - last_fall, iv_exp);
          iv_exp = iv_later;
        end
        last_fall = cyc;
        in_frame = 1; edges = 0; lvl = 1;
      end else if (!spi_cs_n && in_frame) begin
        if (spi_sclk != p_sclk) begin
          chk(lvl == d, "R2 serial clock level length", lvl, d);
          lvl = 1;
          if (spi_sclk) edges++;
        end else lvl++;
      end else if (!p_cs && spi_cs_n && in_frame) begin
        chk(lvl == d, "R2 chip-select hold after last edge", lvl, d);
        chk(edges == FB, "R1 rising edges per frame", edges, FB);
        in_frame = 0; gap = 1; frames_done++;
      end else if (spi_cs_n) gap++;
      p_cs = spi_cs_n; p_sclk = spi_sclk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, sh;
    cfg_period = '0; cfg_div = 4'd1; cfg_shift = '0; cfg_blk_last = '0;
    do_reset;
    // R12 reset state
    chk(spi_cs_n == 1'b1, "R12 cs after reset", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R12 sclk after reset", int'(spi_sclk), 0);
    chk(blk_ready == 1'b0, "R12 ready after reset", int'(blk_ready), 0);
    chk(overflow == 1'b0, "R12 overflow after reset", int'(overflow), 0);

    // R3 R6 R7 sweep of divider and extraction shift, two blocks of four
    for (int d = 1; d <= 3; d++) begin
      for (int s = 0; s < 3; s++) begin
        sh = s * 5;
        seed = FB'(d * 77777 + s * 12345);
        p = 49 * d + 10;
        cfg_div = DIVW'(d); cfg_shift = 5'(sh); cfg_period = TW'(p); cfg_blk_last = AW'(3);
        do_reset;
        start_run(p + 1, p + 1);
        wait_frames(3);
        chk(blk_ready == 1'b0, "R6 not ready before block end", int'(blk_ready), 0);
        wait_frames(4);
        chk(blk_ready == 1'b1 && blk_half == 1'b0, "R6 half 0 ready", int'({blk_ready, blk_half}), 2);
        wait_frames(8);
        stop_run;
        chk(blk_ready == 1'b1 && blk_half == 1'b0, "R7 oldest half offered", int'({blk_ready, blk_half}), 2);
        read_check(0, 4, sh, "R3 half 0 data");
        release_pulse;
        chk(blk_ready == 1'b1 && blk_half == 1'b1, "R7 half 1 after release", int'({blk_ready, blk_half}), 3);
        read_check(4, 4, sh, "R3 half 1 data");
        release_pulse;
        chk(blk_ready == 1'b0, "R7 nothing ready after releases", int'(blk_ready), 0);
        chk(overflow == 1'b0, "R9 no overflow in normal run", int'(overflow), 0);
      end
    end

    // R8 R10 timer expiry during a busy frame
    seed = 22'h2B3C1; cfg_div = 4'd1; cfg_shift = 5'd2; cfg_period = TW'(20); cfg_blk_last = AW'(7);
    do_reset;
    start_run(21, 63);
    wait_frames(1);
    chk(overflow == 1'b1, "R8 overflow on busy expiry", int'(overflow), 1);
    wait_frames(3);
    stop_run;
    repeat (100) step;
    release_pulse;
    chk(overflow == 1'b1, "R10 overflow stays set", int'(overflow), 1);

    // R9 R7 both halves held, dropped sample, ignored release
    seed = 22'h0F0F3; cfg_div = 4'd1; cfg_shift = 5'd3; cfg_period = TW'(60); cfg_blk_last = AW'(1);
    do_reset;
    start_run(61, 61);
    wait_frames(4);
    chk(overflow == 1'b0, "R9 no overflow with both halves just filled", int'(overflow), 0);
    chk(blk_ready == 1'b1 && blk_half == 1'b0, "R6 two-sample block ready", int'({blk_ready, blk_half}), 2);
    wait_frames(5);
    stop_run;
    chk(overflow == 1'b1, "R9 overflow on full buffer", int'(overflow), 1);
    read_check(0, 2, 3, "R9 half 0 kept");
    release_pulse;
    read_check(2, 2, 3, "R9 half 1 kept");
    release_pulse;
    chk(blk_ready == 1'b0, "R7 none ready", int'(blk_ready), 0);
    release_pulse;
    start_run(61, 61);
    wait_frames(7);
    stop_run;
    chk(blk_ready == 1'b1 && blk_half == 1'b0, "R7 idle release ignored", int'({blk_ready, blk_half}), 2);
    read_check(5, 2, 3, "R9 dropped sample skipped");

    // R11 stop in the middle of a frame
    seed = 22'h3A5C7; cfg_div = 4'd3; cfg_shift = 5'd7; cfg_period = TW'(200); cfg_blk_last = AW'(0);
    do_reset;
    start_run(201, 201);
    while (spi_cs_n) step;
    repeat (20) step;
    stop_run;
    wait_frames(1);
    chk(blk_ready == 1'b1, "R11 stopped frame stored", int'(blk_ready), 1);
    read_check(0, 1, 7, "R11 stopped frame data");
    repeat (3 * 201) step;
    chk(frames_done == 1 && spi_cs_n == 1'b1, "R11 no frame after stop", frames_done, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule